// File: doc/BRIEF.md
# Two-Wide In-Order Issue Pairing Unit

This block is the issue stage of an in-order processor with two execution pipes of unequal capability. A fetch buffer presents up to two instructions per cycle: an older one and a younger one. The main pipe accepts any instruction. The lite pipe accepts only simple integer work, simple floating-point work and branches. Each cycle the block decides whether the two candidates can go out together. The older candidate always goes to the main pipe. The younger one goes to the lite pipe only when it qualifies for that pipe and does not depend on the older one.

When the younger candidate cannot go out with the older one, it is not sent back to be fetched again. It stays in a one-entry holding register. On the next cycle it becomes the older candidate, and the instruction at the head of the fetch buffer is its partner. In that case the block takes only one new instruction from fetch. The `fetch_take_o` count tells the fetch buffer how far to advance. The issue outputs are registered. A low ready on either pipe freezes the whole stage.

Top module: `dual_issue_pair`

## Requirements
- R1: While reset is high, and at the first clock edge after it, both `main_valid_o` and `lite_valid_o` are 0, and the holding register is empty.
- R2: The instruction class is taken from bits [31:29]. Value 0 is simple integer, 1 is simple floating-point, 2 is complex and 3 is branch. Values 4 to 7 are handled exactly like complex.
- R3: Issue is in order. The older candidate always goes to the main pipe. `lite_valid_o` is never 1 unless `main_valid_o` is also 1.
- R4: A pair issues together, one instruction to each pipe, when all three conditions hold: the older class is 0 or 1, the younger class is 0, 1 or 3, and the two instructions have no register dependence. When no instruction is held, a cycle that issues from fetch reports `fetch_take_o` = 2.
- R5: When the older candidate is complex or a branch, or the younger candidate is complex (classes 2 and 4 to 7), only the older candidate issues, and the younger one is held.
- R6: The registers sit at fixed fields: destination in bits [24:20], first source in [19:15] and second source in [14:10]. If any of the younger's three fields equals the older's destination, the two do not pair, and only the older candidate issues.
- R7: A held instruction becomes the older candidate on the next issuing cycle. Its partner is `fetch_old_i`, and the cycle reports `fetch_take_o` = 1. If that pairing also fails, `fetch_old_i` becomes the new held instruction.
- R8: If an instruction is held and `fetch_valid_i` is 0, the held instruction issues alone to the main pipe, and `fetch_take_o` is 0.
- R9: If `main_ready_i` or `lite_ready_i` is 0, nothing issues. The outputs keep their values, `fetch_take_o` is 0, and the holding register is unchanged.
- R10: The issue outputs are registered. A decision made from the inputs of one cycle appears on the outputs after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | Fetch buffer is presenting two instructions |
| fetch_old_i | input | 32 | Older instruction at the head of the fetch buffer |
| fetch_young_i | input | 32 | Next instruction after the head |
| fetch_take_o | output | 2 | Number of fetch instructions consumed this cycle (0, 1 or 2) |
| main_ready_i | input | 1 | Main pipe can accept an instruction |
| main_valid_o | output | 1 | Main pipe instruction is valid |
| main_instr_o | output | 32 | Instruction issued to the main pipe |
| lite_ready_i | input | 1 | Lite pipe can accept an instruction |
| lite_valid_o | output | 1 | Lite pipe instruction is valid |
| lite_instr_o | output | 32 | Instruction issued to the lite pipe |

## Verification
The assertions assume that the fetch buffer advances by exactly `fetch_take_o` each cycle. They also assume that, after such an advance, `fetch_old_i` and `fetch_young_i` are always the next two instructions of one ordered stream. The bench keeps that contract by holding the whole program in an array with a read pointer. It presents the instructions at the pointer and the one after it, and moves the pointer only by the count its own model predicts, which it also compares against `fetch_take_o`. Fetch bubbles and low ready values are drawn at random. The register numbers come from a small set, so that register dependences occur often.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;
   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      KIND_INT  = 3'd0,
      KIND_FP   = 3'd1,
      KIND_CPLX = 3'd2,
      KIND_BR   = 3'd3
   } kind_e;
endpackage

// File: rtl/pair_decode.sv
module pair_decode
   import dual_issue_pkg::*;
#(
   parameter int INSTR_W  = 32,
   parameter int CLS_LSB  = 29,
   parameter int DST_LSB  = 20,
   parameter int SRC0_LSB = 15,
   parameter int REG_W    = 5,
   parameter int NUM_SRC  = 2
) (
   input  logic [INSTR_W-1:0]       instr,
   output kind_e                    kind,
   output logic [REG_W-1:0]         dst,
   output logic [NUM_SRC*REG_W-1:0] srcs
);
   localparam int LAST_SRC_LSB = SRC0_LSB - (NUM_SRC - 1) * REG_W;

   if (LAST_SRC_LSB < 0) begin : g_bad_src
      $error("pair_decode: source fields fall below bit 0");
   end
   if (CLS_LSB + CLS_W > INSTR_W) begin : g_bad_cls
      $error("pair_decode: class field exceeds instruction width");
   end

   logic [CLS_W-1:0] raw_cls;
   logic             spare_unused;

   assign raw_cls      = instr[CLS_LSB +: CLS_W];
   assign dst          = instr[DST_LSB +: REG_W];
   assign spare_unused = ^instr;

   // classes beyond the defined four are treated as complex
   always_comb begin
      unique case (raw_cls)
         3'd0:    kind = KIND_INT;
         3'd1:    kind = KIND_FP;
         3'd3:    kind = KIND_BR;
         default: kind = KIND_CPLX;
      endcase
   end

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      localparam int LSB = SRC0_LSB - k * REG_W;
      assign srcs[k*REG_W +: REG_W] = instr[LSB +: REG_W];
   end
endmodule

// File: rtl/pair_hazard.sv
module pair_hazard #(
   parameter int REG_W   = 5,
   parameter int NUM_SRC = 2
) (
   input  logic [REG_W-1:0]         older_dst,
   input  logic [REG_W-1:0]         young_dst,
   input  logic [NUM_SRC*REG_W-1:0] young_srcs,
   output logic                     conflict
);
   if (NUM_SRC < 1 || NUM_SRC > 3) begin : g_bad_cnt
      $error("pair_hazard: NUM_SRC must be 1 to 3");
   end

   logic [NUM_SRC-1:0] raw_hit;

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_cmp
      assign raw_hit[k] = (young_srcs[k*REG_W +: REG_W] == older_dst);
   end

   // read-after-write on any source, or write-after-write on the destination
   assign conflict = (|raw_hit) | (young_dst == older_dst);
endmodule

// File: rtl/pair_rules.sv
module pair_rules
   import dual_issue_pkg::*;
#(
   parameter bit FP_TO_LITE = 1'b1
) (
   input  kind_e older_kind,
   input  kind_e young_kind,
   input  logic  conflict,
   output logic  can_pair
);
   logic older_ok;
   logic young_ok;

   // only simple work may lead a pair; branches and complex go alone
   assign older_ok = (older_kind == KIND_INT) | (older_kind == KIND_FP);

   if (FP_TO_LITE) begin : g_fp_lite
      assign young_ok = (young_kind == KIND_INT) | (young_kind == KIND_FP) |
                        (young_kind == KIND_BR);
   end else begin : g_int_lite
      assign young_ok = (young_kind == KIND_INT) | (young_kind == KIND_BR);
   end

   assign can_pair = older_ok & young_ok & ~conflict;
endmodule

// File: rtl/pair_hold.sv
module pair_hold #(
   parameter int INSTR_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic               clear,
   input  logic [INSTR_W-1:0] d,
   output logic               valid,
   output logic [INSTR_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         q     <= '0;
      end else if (load) begin
         valid <= 1'b1;
         q     <= d;
      end else if (clear) begin
         valid <= 1'b0;
      end
   end

   AST_HOLD_LOAD_SETS: assert property (@(posedge clk) disable iff (rst)
      load |=> valid && (q == $past(d))) else $error("hold load lost"); // R7
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
   import dual_issue_pkg::*;
#(
   parameter int INSTR_W    = 32,
   parameter int CLS_LSB    = 29,
   parameter int DST_LSB    = 20,
   parameter int SRC0_LSB   = 15,
   parameter int REG_W      = 5,
   parameter int NUM_SRC    = 2,
   parameter bit FP_TO_LITE = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               fetch_valid_i,
   input  logic [INSTR_W-1:0] fetch_old_i,
   input  logic [INSTR_W-1:0] fetch_young_i,
   output logic [1:0]         fetch_take_o,
   input  logic               main_ready_i,
   output logic               main_valid_o,
   output logic [INSTR_W-1:0] main_instr_o,
   input  logic               lite_ready_i,
   output logic               lite_valid_o,
   output logic [INSTR_W-1:0] lite_instr_o
);
   localparam int SRCS_W = NUM_SRC * REG_W;

   if (INSTR_W < 8) begin : g_bad_w
      $error("dual_issue_pair: instruction width too small");
   end
   if (DST_LSB + REG_W > INSTR_W) begin : g_bad_dst
      $error("dual_issue_pair: destination field exceeds instruction width");
   end

   logic               advance;
   logic               hold_v;
   logic [INSTR_W-1:0] hold_q;
   logic               old_v;
   logic               yng_v;
   logic [INSTR_W-1:0] old_instr;
   logic [INSTR_W-1:0] yng_instr;
   kind_e              old_kind;
   kind_e              yng_kind;
   logic [REG_W-1:0]   old_dst;
   logic [REG_W-1:0]   yng_dst;
   logic [SRCS_W-1:0]  old_srcs;
   logic [SRCS_W-1:0]  yng_srcs;
   logic               conflict;
   logic               can_pair;
   logic               issue_main;
   logic               issue_lite;
   logic               hold_load;
   logic               hold_clear;
   logic               old_srcs_unused;

   assign advance = main_ready_i & lite_ready_i;

   // a held leftover is always older than anything at the fetch head
   assign old_v     = hold_v | fetch_valid_i;
   assign yng_v     = fetch_valid_i;
   assign old_instr = hold_v ? hold_q : fetch_old_i;
   assign yng_instr = hold_v ? fetch_old_i : fetch_young_i;

   pair_decode #(
      .INSTR_W(INSTR_W), .CLS_LSB(CLS_LSB), .DST_LSB(DST_LSB),
      .SRC0_LSB(SRC0_LSB), .REG_W(REG_W), .NUM_SRC(NUM_SRC)
   ) u_dec_old (
      .instr(old_instr), .kind(old_kind), .dst(old_dst), .srcs(old_srcs)
   );

   pair_decode #(
      .INSTR_W(INSTR_W), .CLS_LSB(CLS_LSB), .DST_LSB(DST_LSB),
      .SRC0_LSB(SRC0_LSB), .REG_W(REG_W), .NUM_SRC(NUM_SRC)
   ) u_dec_yng (
      .instr(yng_instr), .kind(yng_kind), .dst(yng_dst), .srcs(yng_srcs)
   );

   assign old_srcs_unused = ^old_srcs;

   pair_hazard #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_hazard (
      .older_dst(old_dst), .young_dst(yng_dst), .young_srcs(yng_srcs),
      .conflict(conflict)
   );

   pair_rules #(.FP_TO_LITE(FP_TO_LITE)) u_rules (
      .older_kind(old_kind), .young_kind(yng_kind), .conflict(conflict),
      .can_pair(can_pair)
   );

   assign issue_main = advance & old_v;
   assign issue_lite = advance & yng_v & can_pair;
   assign hold_load  = advance & yng_v & ~can_pair;
   assign hold_clear = advance & hold_v;

   pair_hold #(.INSTR_W(INSTR_W)) u_hold (
      .clk(clk), .rst(rst), .load(hold_load), .clear(hold_clear),
      .d(yng_instr), .valid(hold_v), .q(hold_q)
   );

   always_comb begin
      if (!(advance && fetch_valid_i)) fetch_take_o = 2'd0;
      else if (hold_v)                 fetch_take_o = 2'd1;
      else                             fetch_take_o = 2'd2;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         main_valid_o <= 1'b0;
         lite_valid_o <= 1'b0;
         main_instr_o <= '0;
         lite_instr_o <= '0;
      end else if (advance) begin
         main_valid_o <= issue_main;
         lite_valid_o <= issue_lite;
         main_instr_o <= old_instr;
         lite_instr_o <= yng_instr;
      end
   end

   AST_LITE_NEEDS_MAIN: assert property (@(posedge clk) disable iff (rst)
      lite_valid_o |-> main_valid_o) else $error("lite issued alone"); // R3

   AST_LITE_CLASS_OK: assert property (@(posedge clk) disable iff (rst)
      lite_valid_o |-> (lite_instr_o[CLS_LSB +: CLS_W] == 3'd0) ||
                       (FP_TO_LITE && lite_instr_o[CLS_LSB +: CLS_W] == 3'd1) ||
                       (lite_instr_o[CLS_LSB +: CLS_W] == 3'd3))
      else $error("lite got a class it cannot run"); // R4

   AST_LEADER_SIMPLE: assert property (@(posedge clk) disable iff (rst)
      lite_valid_o |-> main_instr_o[CLS_LSB +: CLS_W] <= 3'd1)
      else $error("pair led by complex or branch"); // R5

   AST_PAIR_NO_DEP: assert property (@(posedge clk) disable iff (rst)
      lite_valid_o |->
         (lite_instr_o[DST_LSB +: REG_W]  != main_instr_o[DST_LSB +: REG_W]) &&
         (lite_instr_o[SRC0_LSB +: REG_W] != main_instr_o[DST_LSB +: REG_W]))
      else $error("dependent pair issued"); // R6

   AST_HELD_TAKES_ONE: assert property (@(posedge clk) disable iff (rst)
      hold_v && fetch_take_o != 2'd0 |-> fetch_take_o == 2'd1)
      else $error("took two with a leftover held"); // R7

   AST_TAKE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      !fetch_valid_i |-> fetch_take_o == 2'd0)
      else $error("consumed from empty fetch"); // R8

   AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
      !rst && !advance |=> $stable(main_valid_o) && $stable(lite_valid_o) &&
                           $stable(main_instr_o) && $stable(hold_v))
      else $error("state moved during stall"); // R9
endmodule

// File: tb/dual_issue_pair_test.sv
module dual_issue_pair_test;
   localparam int NSTR = 2048;
   localparam int NCYC = 3000;

   logic        clk = 1'b0;
   logic        rst;
   logic        fetch_valid_i;
   logic [31:0] fetch_old_i;
   logic [31:0] fetch_young_i;
   logic [1:0]  fetch_take_o;
   logic        main_ready_i;
   logic        main_valid_o;
   logic [31:0] main_instr_o;
   logic        lite_ready_i;
   logic        lite_valid_o;
   logic [31:0] lite_instr_o;

   dual_issue_pair uut (
      .clk(clk), .rst(rst), .fetch_valid_i(fetch_valid_i),
      .fetch_old_i(fetch_old_i), .fetch_young_i(fetch_young_i),
      .fetch_take_o(fetch_take_o), .main_ready_i(main_ready_i),
      .main_valid_o(main_valid_o), .main_instr_o(main_instr_o),
      .lite_ready_i(lite_ready_i), .lite_valid_o(lite_valid_o),
      .lite_instr_o(lite_instr_o)
   );

   always #4 clk = ~clk;

   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;
   logic [31:0] strm [NSTR];
   int          ptr = 0;
   bit          m_hv = 1'b0;
   logic [31:0] m_hi = '0;
   bit          e_mv = 1'b0;
   bit          e_lv = 1'b0;
   logic [31:0] e_mi = '0;
   logic [31:0] e_li = '0;
   string       e_tag = "R1";

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int c, input int d, input int a, input int b);
      logic [31:0] r;
      r = '0;
      r[31:29] = 3'(c);
      r[24:20] = 5'(d);
      r[19:15] = 5'(a);
      r[14:10] = 5'(b);
      return r;
   endfunction

   function automatic bit lead_ok(input logic [31:0] x);
      return x[31:29] <= 3'd1;
   endfunction

   function automatic bit lite_ok(input logic [31:0] x);
      return x[31:29] <= 3'd1 || x[31:29] == 3'd3;
   endfunction

   function automatic bit depends(input logic [31:0] o, input logic [31:0] y);
      return y[24:20] == o[24:20] || y[19:15] == o[24:20] || y[14:10] == o[24:20];
   endfunction

   function automatic string why_single(input logic [31:0] o, input logic [31:0] y);
      if (y[31:29] >= 3'd4) return "R2";
      if (!lead_ok(o) || !lite_ok(y)) return "R5";
      return "R6";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      // directed prefix
      strm[0]  = mk(0, 1, 2, 3);   strm[1]  = mk(0, 4, 5, 6);   // clean pair
      strm[2]  = mk(0, 1, 2, 3);   strm[3]  = mk(0, 7, 1, 9);   // RAW on src1
      strm[4]  = mk(0, 8, 9, 10);                               // pairs with held 3
      strm[5]  = mk(2, 11, 0, 0);  strm[6]  = mk(0, 12, 0, 0);  // complex leader
      strm[7]  = mk(3, 13, 14, 0);                              // branch as younger
      strm[8]  = mk(3, 15, 0, 0);  strm[9]  = mk(0, 16, 0, 0);  // branch leader
      strm[10] = mk(6, 17, 0, 0);                               // class 6 younger
      strm[11] = mk(1, 18, 19, 20); strm[12] = mk(1, 21, 18, 0); // FP, RAW on src
      strm[13] = mk(0, 22, 0, 21);                              // RAW on src2
      strm[14] = mk(0, 22, 1, 2);                               // WAW
      for (int i = 15; i < NSTR; i++) begin
         int r;
         int c;
         r = int'($urandom % 10);
         c = (r <= 4) ? 0 : (r == 5) ? 1 : (r == 6) ? 2 : (r == 8) ? 4 + int'($urandom % 4) : 3;
         strm[i] = $urandom;
         strm[i][31:29] = 3'(c);
         strm[i][24:20] = 5'($urandom % 4);
         strm[i][19:15] = 5'($urandom % 4);
         strm[i][14:10] = 5'($urandom % 4);
      end

      rst = 1'b1;
      fetch_valid_i = 1'b0;
      fetch_old_i = '0;
      fetch_young_i = '0;
      main_ready_i = 1'b1;
      lite_ready_i = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", 32'(main_valid_o), 32'd0);
      chk("R1", 32'(lite_valid_o), 32'd0);
      rst = 1'b0;
      #1;
      chk("R1", 32'(fetch_take_o), 32'd0);

      for (int cyc = 0; cyc < NCYC; cyc++) begin
         bit          adv;
         int          take;
         logic [31:0] o;
         logic [31:0] y;
         string       ttag;
         @(negedge clk);
         chk(e_tag, 32'(main_valid_o), 32'(e_mv));
         if (e_mv) chk(e_tag, main_instr_o, e_mi);
         chk(e_tag, 32'(lite_valid_o), 32'(e_lv));
         if (e_lv) chk(e_tag, lite_instr_o, e_li);

         main_ready_i  = (cyc < 16) ? 1'b1 : ($urandom % 5 != 0);
         lite_ready_i  = (cyc < 16) ? 1'b1 : ($urandom % 6 != 0);
         fetch_valid_i = (ptr + 1 < NSTR) && ((cyc < 16) || ($urandom % 5 != 0));
         fetch_old_i   = (ptr < NSTR) ? strm[ptr] : '0;
         fetch_young_i = (ptr + 1 < NSTR) ? strm[ptr + 1] : '0;
         #1;
         chk("R10", 32'(main_valid_o), 32'(e_mv));

         adv  = main_ready_i && lite_ready_i;
         take = 0;
         ttag = "R4";
         if (!adv) begin
            ttag  = "R9";
            e_tag = "R9";
         end else if (m_hv) begin
            o = m_hi;
            ttag = "R7";
            if (fetch_valid_i) begin
               y = fetch_old_i;
               take = 1;
               e_mv = 1'b1; e_mi = o;
               if (lead_ok(o) && lite_ok(y) && !depends(o, y)) begin
                  e_lv = 1'b1; e_li = y; m_hv = 1'b0; e_tag = "R7";
               end else begin
                  e_lv = 1'b0; m_hv = 1'b1; m_hi = y; e_tag = why_single(o, y);
               end
            end else begin
               ttag = "R8";
               e_mv = 1'b1; e_mi = o; e_lv = 1'b0; m_hv = 1'b0; e_tag = "R8";
            end
         end else if (fetch_valid_i) begin
            o = fetch_old_i;
            y = fetch_young_i;
            take = 2;
            e_mv = 1'b1; e_mi = o;
            if (lead_ok(o) && lite_ok(y) && !depends(o, y)) begin
               e_lv = 1'b1; e_li = y; e_tag = "R4";
            end else begin
               e_lv = 1'b0; m_hv = 1'b1; m_hi = y; e_tag = why_single(o, y);
            end
         end else begin
            e_mv = 1'b0; e_lv = 1'b0; e_tag = "R3";
         end
         chk(ttag, 32'(fetch_take_o), 32'(take));
         ptr += take;
      end

      @(negedge clk);
      chk(e_tag, 32'(main_valid_o), 32'(e_mv));
      chk(e_tag, 32'(lite_valid_o), 32'(e_lv));
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule